// File: doc/BRIEF.md
# Master-Slave PWM Timer Group

The block is a timer group with one master channel and a parameterised number of slave channels (two by default). Together they produce PWM waveforms that all share one period. The master counts down from a programmed period value. It reloads that value when it reaches zero, and in the same count step it issues a one-cycle period event. Each slave is a one-shot down-counter. On each period event a slave loads its own duty value, drives its active level, and releases it when the count runs out. The duty width is set per slave, while the period is common to all of them.

Counting advances only on one of two prescaled clock-enable inputs, chosen by a clock-select field. Software configures the group through a single-cycle register write port. Each slave output is conditioned by an enable bit, a polarity bit, a manual level and an output-mode bit. When counting does not control the pin, the pin shows the manual level.

Top module: `pwm_group_top`

## Requirements
- R1: After a synchronous active-low reset, every register is zero and every `pwm_out` bit is 0.
- R2: The master period value is at address 0. Master control is at address 1, with bit 0 = run and bits [2:1] = clock select. A clock select of 00 counts on `clk_en0`, 10 counts on `clk_en1`, and any other value does not count. While running, the master issues one period event every N+1 selected ticks, where N is the period value. The first event comes on the first tick after run is set.
- R3: Slave s (s = 0, 1, …) has its duty at address 4+4s, its mode word at 5+4s and its output control at 6+4s. On an accepted period event the slave loads duty D and becomes active in the following cycle. It stays active for exactly D of its ticks.
- R4: A duty of 0 keeps the slave inactive.
- R5: When retrigger is enabled and D > N, the output is constantly active. A period event that falls on the tick where the count ends wins over the expiry.
- R6: When retrigger is disabled (mode bit 0 = 0), a period event that arrives while the slave is active is ignored and counting continues.
- R7: In output control, bit 1 is polarity. With polarity 0 the output is active-high; with polarity 1 it is active-low.
- R8: In output control, bit 0 is output enable, bit 2 is the manual level and bit 3 is slave output mode. Unless both bit 0 and bit 3 are 1, the pin equals bit 2 regardless of counting.
- R9: The mode word has bits [3:1] = mode, [6:4] = trigger select, [8:7] = clock select, [9] = count source and [11:10] = edge select. A slave accepts period events only when the mode is 100, the trigger select is 100, the count source is 0, the edge select is 00 and the clock select equals the master's.
- R10: A slave counts only on the clock enable chosen by its clock select, so its active time in clock cycles scales with the enable rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register address |
| wr_data | input | CNT_W (16) | Register write data |
| clk_en0 | input | 1 | First prescaled clock enable |
| clk_en1 | input | 1 | Second prescaled clock enable |
| pwm_out | output | NUM_SLAVES (2) | One PWM output per slave |

## Verification
The critical coincidence is a slave's count expiring on the same tick that the next period event arrives. This is provoked by setting the duty to N+1, and to N+1 or more with N = 0, with retrigger enabled. It is judged by the output never going inactive across whole periods. Setting the duty equal to N provokes the neighbouring case, where expiry comes exactly one tick before the event and the output must show one inactive tick per period. With retrigger disabled, events that land mid-count must be dropped, which stretches the waveform period to a multiple of N+1. Active-time counts taken over whole periods reveal this.

// File: rtl/pwm_pkg.sv
// Shared types and helpers for the PWM timer group.
// Assumes mode words are 12 bits and output control words are 4 bits.
package pwm_pkg;

    localparam int MODE_W = 12;
    localparam int OUTC_W = 4;

    // Slave mode word, MSB first: edge sel, count source, clock sel, trigger sel, mode.
    typedef struct packed {
        logic [1:0] edge_sel;
        logic       cnt_src;
        logic [1:0] clk_sel;
        logic [2:0] trg_sel;
        logic [3:0] mode;
    } smode_t;

    // Slave output control word: slave-mode, manual level, polarity, enable.
    typedef struct packed {
        logic slave_mode;
        logic manual;
        logic pol;
        logic oe;
    } soutc_t;

    // Picks the count tick for a clock-select code; unsupported codes never tick.
    function automatic logic pick_tick(input logic [1:0] sel, input logic en0, input logic en1);
        case (sel)
            2'b00:   pick_tick = en0;
            2'b10:   pick_tick = en1;
            default: pick_tick = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_regs.sv
// Register file for the PWM timer group.
// Holds the master period and control plus per-slave duty, mode and output control.
// Assumes single-cycle writes; no read path is provided.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NS     = 2,
    parameter int ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CNT_W-1:0]              wr_data,
    output logic [CNT_W-1:0]              period,
    output logic                          run,
    output logic [1:0]                    m_clk_sel,
    output logic [NS-1:0][CNT_W-1:0]      duty,
    output logic [NS-1:0][MODE_W-1:0]     mode,
    output logic [NS-1:0][OUTC_W-1:0]     outc
);

    logic [CNT_W-1:0] period_q;
    logic [2:0]       mctrl_q;

    // Master period and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            mctrl_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(0)) period_q <= wr_data;
            if (wr_addr == ADDR_W'(1)) mctrl_q  <= wr_data[2:0];
        end
    end

    assign period    = period_q;
    assign run       = mctrl_q[0];
    assign m_clk_sel = mctrl_q[2:1];

    for (genvar s = 0; s < NS; s++) begin : g_slv
        localparam int BASE = 4 * (s + 1);
        logic [CNT_W-1:0]  duty_q;
        logic [MODE_W-1:0] mode_q;
        logic [OUTC_W-1:0] outc_q;

        // Per-slave duty, mode and output control registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty_q <= '0;
                mode_q <= '0;
                outc_q <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(BASE))     duty_q <= wr_data;
                if (wr_addr == ADDR_W'(BASE + 1)) mode_q <= wr_data[MODE_W-1:0];
                if (wr_addr == ADDR_W'(BASE + 2)) outc_q <= wr_data[OUTC_W-1:0];
            end
        end

        assign duty[s] = duty_q;
        assign mode[s] = mode_q;
        assign outc[s] = outc_q;
    end

endmodule

// File: rtl/pwm_master.sv
// Master interval counter: counts down on its selected tick and reloads the period.
// Issues a one-cycle period event on each tick where the count is zero.
// Assumes the count is cleared while stopped so the first tick after start fires.
module pwm_master
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       clk_sel,
    input  logic             en0,
    input  logic             en1,
    input  logic [CNT_W-1:0] period,
    output logic             tick,
    output logic             trig,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = pick_tick(clk_sel, en0, en1);
    assign trig = run && tick && (cnt_q == '0);
    assign cnt  = cnt_q;

    // Down-count with reload; held at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == '0) ? period : cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pwm_slave.sv
// Slave one-shot duty channel: loads its duty on an accepted period event, stays
// active for that many ticks, and drives a conditioned output pin.
// Assumes its tick matches the master's whenever its configuration is valid.
module pwm_slave
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [1:0]        m_clk_sel,
    input  logic              en0,
    input  logic              en1,
    input  logic [CNT_W-1:0]  duty,
    input  logic [MODE_W-1:0] mode_w,
    input  logic [OUTC_W-1:0] outc_w,
    output logic              armed,
    output logic              active,
    output logic [CNT_W-1:0]  cnt,
    output logic              pin
);

    smode_t           md;
    soutc_t           oc;
    logic             tick;
    logic             accept;
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    assign md   = smode_t'(mode_w);
    assign oc   = soutc_t'(outc_w);
    assign tick = pick_tick(md.clk_sel, en0, en1);

    // Configuration check: one-shot mode, master trigger, internal clock, matching prescaler.
    assign armed = (md.mode[3:1] == 3'b100) && (md.trg_sel == 3'b100) && !md.cnt_src
                && (md.edge_sel == 2'b00) && (md.clk_sel == m_clk_sel);

    assign accept = trig && armed && (!active_q || md.mode[0]);

    // Load on accepted event (wins over expiry), otherwise count down while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (accept) begin
            active_q <= (duty != '0);
            cnt_q    <= duty;
        end else if (tick && active_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) active_q <= 1'b0;
        end
    end

    // Pin: counted level with polarity when enabled in slave mode, else the manual level.
    assign pin    = (oc.oe && oc.slave_mode) ? (active_q ^ oc.pol) : oc.manual;
    assign active = active_q;
    assign cnt    = cnt_q;

endmodule

// File: rtl/pwm_group_top.sv
// PWM timer group top: one master period counter driving NUM_SLAVES one-shot
// duty channels, configured through a write-only register port.
// Assumes clock enables are single-cycle pulses synchronous to clk.
module pwm_group_top
    import pwm_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int NUM_SLAVES = 2,
    parameter int ADDR_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic                  clk_en0,
    input  logic                  clk_en1,
    output logic [NUM_SLAVES-1:0] pwm_out
);

    logic [CNT_W-1:0]                    period;
    logic                                run;
    logic [1:0]                          m_clk_sel;
    logic [NUM_SLAVES-1:0][CNT_W-1:0]    duty;
    logic [NUM_SLAVES-1:0][MODE_W-1:0]   mode;
    logic [NUM_SLAVES-1:0][OUTC_W-1:0]   outc;
    logic                                m_tick;
    logic                                m_trig;
    logic [CNT_W-1:0]                    m_cnt;
    logic [NUM_SLAVES-1:0]               s_armed;
    logic [NUM_SLAVES-1:0]               s_active;
    logic [NUM_SLAVES-1:0][CNT_W-1:0]    s_cnt;

    pwm_regs #(.CNT_W(CNT_W), .NS(NUM_SLAVES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .period    (period),
        .run       (run),
        .m_clk_sel (m_clk_sel),
        .duty      (duty),
        .mode      (mode),
        .outc      (outc)
    );

    pwm_master #(.CNT_W(CNT_W)) u_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clk_sel (m_clk_sel),
        .en0     (clk_en0),
        .en1     (clk_en1),
        .period  (period),
        .tick    (m_tick),
        .trig    (m_trig),
        .cnt     (m_cnt)
    );

    for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_ch
        pwm_slave #(.CNT_W(CNT_W)) u_slave (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig      (m_trig),
            .m_clk_sel (m_clk_sel),
            .en0       (clk_en0),
            .en1       (clk_en1),
            .duty      (duty[s]),
            .mode_w    (mode[s]),
            .outc_w    (outc[s]),
            .armed     (s_armed[s]),
            .active    (s_active[s]),
            .cnt       (s_cnt[s]),
            .pin       (pwm_out[s])
        );
    end

endmodule

// File: rtl/pwm_group_chk.sv
// Assertion checker for the PWM timer group, attached to the top by bind.
// Relates the master event, slave state and pins across clock cycles.
module pwm_group_chk
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NS    = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      m_tick,
    input logic                      m_trig,
    input logic [CNT_W-1:0]          m_cnt,
    input logic [CNT_W-1:0]          period,
    input logic [NS-1:0]             s_armed,
    input logic [NS-1:0]             s_active,
    input logic [NS-1:0][CNT_W-1:0]  s_cnt,
    input logic [NS-1:0][CNT_W-1:0]  duty,
    input logic [NS-1:0][MODE_W-1:0] mode,
    input logic [NS-1:0][OUTC_W-1:0] outc,
    input logic [NS-1:0]             pwm_out
);

    // R2: a period event reloads the master with the period value.
    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        m_trig |=> m_cnt == $past(period));

    for (genvar s = 0; s < NS; s++) begin : g_s
        // R3: accepted event on an idle slave starts an active count of D.
        a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
            (m_trig && s_armed[s] && !s_active[s] && duty[s] != '0)
            |=> (s_active[s] && s_cnt[s] == $past(duty[s])));

        // R4: an accepted event with zero duty leaves the slave inactive.
        a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (m_trig && s_armed[s] && (!s_active[s] || mode[s][0]) && duty[s] == '0)
            |=> !s_active[s]);

        // R6: without retrigger an event mid-count only decrements.
        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (m_trig && s_armed[s] && s_active[s] && !mode[s][0] && s_cnt[s] > CNT_W'(1))
            |=> (s_active[s] && s_cnt[s] == CNT_W'($past(s_cnt[s]) - 1'b1)));

        // R3: the last tick without an event ends the active phase.
        a_r3_expire: assert property (@(posedge clk) disable iff (!rst_n)
            (s_armed[s] && s_active[s] && m_tick && !m_trig && s_cnt[s] == CNT_W'(1))
            |=> !s_active[s]);

        // R8: outside enabled slave mode the pin shows the manual level.
        a_r8_manual: assert property (@(posedge clk) disable iff (!rst_n)
            !(outc[s][0] && outc[s][3]) |-> pwm_out[s] == outc[s][2]);
    end

endmodule

bind pwm_group_top pwm_group_chk #(.CNT_W(CNT_W), .NS(NUM_SLAVES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_tick   (m_tick),
    .m_trig   (m_trig),
    .m_cnt    (m_cnt),
    .period   (period),
    .s_armed  (s_armed),
    .s_active (s_active),
    .s_cnt    (s_cnt),
    .duty     (duty),
    .mode     (mode),
    .outc     (outc),
    .pwm_out  (pwm_out)
);

// File: tb/pwm_group_top_test.sv
`timescale 1ns/1ps
// Bench for the PWM timer group: a vector table of period/duty setups measured
// over whole periods, then directed tests for reset, manual level, mode checks
// and the exact start timing.
module pwm_group_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        clk_en0 = 1'b1;
    logic        clk_en1 = 1'b0;
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwm_group_top uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clk_en0 (clk_en0),
        .clk_en1 (clk_en1),
        .pwm_out (pwm_out)
    );

    // Second prescaled enable: one tick every two cycles.
    initial forever begin
        @(negedge clk);
        clk_en1 = ~clk_en1;
    end

    typedef struct packed {
        logic [7:0] n;
        logic [7:0] d0;
        logic [7:0] d1;
        logic       pol0;
        logic       pol1;
        logic       rt;
        logic       slow;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'd4, 8'd2, 8'd3, 1'b0, 1'b0, 1'b1, 1'b0},   // R3 basic widths
        '{8'd7, 8'd0, 8'd8, 1'b0, 1'b0, 1'b1, 1'b0},   // R4 zero, R5 D=N+1
        '{8'd5, 8'd5, 8'd1, 1'b1, 1'b0, 1'b1, 1'b0},   // R7 active-low, D=N
        '{8'd3, 8'd5, 8'd2, 1'b0, 1'b0, 1'b0, 1'b0},   // R6 no retrigger
        '{8'd3, 8'd5, 8'd9, 1'b0, 1'b1, 1'b1, 1'b1},   // R10 slow, R5 constant
        '{8'd6, 8'd3, 8'd6, 1'b0, 1'b0, 1'b0, 1'b1},   // R10 slow, R6 D=N
        '{8'd0, 8'd1, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0}    // R5 N=0 every tick
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = 16'(data);
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Count cycles in which each output is at its active level.
    task automatic measure(input int cycles, input bit p0, input bit p1,
                           output int c0, output int c1);
        c0 = 0;
        c1 = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            c0 += int'(pwm_out[0] ^ p0);
            c1 += int'(pwm_out[1] ^ p1);
        end
    endtask

    // Expected active cycles over a window of 24*(N+1) ticks.
    function automatic int expect_active(input int n, input int d, input bit rt, input int div);
        int mult, wp, hi;
        mult = rt ? 1 : (d + 1 + n) / (n + 1);
        wp   = mult * (n + 1);
        hi   = (d < wp) ? d : wp;
        return (24 / mult) * hi * div;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c0, c1, win, div, e0, e1, mw;

        // R1: reset state.
        repeat (4) @(negedge clk);
        check(pwm_out == 2'b00, "R1 reset outputs", int'(pwm_out), 0);
        rst_n = 1'b1;

        // Vector table: R2, R3, R4, R5, R6, R7, R10.
        for (int v = 0; v < NV; v++) begin
            div = VECS[v].slow ? 2 : 1;
            mw  = 16'h0048 | int'(VECS[v].rt) | (VECS[v].slow ? 16'h0100 : 0);
            wr(1, 0);
            wr(0, int'(VECS[v].n));
            wr(4, int'(VECS[v].d0));
            wr(8, int'(VECS[v].d1));
            wr(5, mw);
            wr(9, mw);
            wr(6, VECS[v].pol0 ? 16'hB : 16'h9);
            wr(10, VECS[v].pol1 ? 16'hB : 16'h9);
            wr(1, VECS[v].slow ? 16'h5 : 16'h1);
            win = 24 * (int'(VECS[v].n) + 1) * div;
            measure(win, VECS[v].pol0, VECS[v].pol1, c0, c1);
            measure(win, VECS[v].pol0, VECS[v].pol1, c0, c1);
            e0 = expect_active(int'(VECS[v].n), int'(VECS[v].d0), VECS[v].rt, div);
            e1 = expect_active(int'(VECS[v].n), int'(VECS[v].d1), VECS[v].rt, div);
            check(c0 == e0, $sformatf("R2/R3 vector %0d slave0", v), c0, e0);
            check(c1 == e1, $sformatf("R2/R3 vector %0d slave1", v), c1, e1);
        end

        // R8: manual level when disabled or not in slave mode.
        wr(1, 0);
        wr(0, 4);
        wr(4, 2);
        wr(8, 2);
        wr(5, 16'h049);
        wr(9, 16'h049);
        wr(6, 16'h4);
        wr(10, 16'h5);
        wr(1, 1);
        measure(40, 1'b0, 1'b0, c0, c1);
        check(c0 == 40, "R8 manual high, output disabled", c0, 40);
        check(c1 == 40, "R8 manual high, not slave mode", c1, 40);

        // R9: invalid mode words ignore period events.
        wr(1, 0);
        wr(6, 16'h9);
        wr(10, 16'h9);
        wr(5, 16'h04C);
        wr(9, 16'h039);
        wr(1, 1);
        measure(40, 1'b0, 1'b0, c0, c1);
        check(c0 == 0, "R9 wrong mode field", c0, 0);
        check(c1 == 0, "R9 wrong trigger select", c1, 0);
        wr(9, 16'h149);
        measure(40, 1'b0, 1'b0, c0, c1);
        check(c1 == 0, "R9 clock select mismatch", c1, 0);

        // R3/R2: exact start timing, D=3, N=9 on clk_en0.
        wr(1, 0);
        wr(0, 9);
        wr(4, 3);
        wr(5, 16'h049);
        wr(1, 1);
        check(pwm_out[0] == 1'b0, "R2 no output before first event", int'(pwm_out[0]), 0);
        measure(3, 1'b0, 1'b0, c0, c1);
        check(c0 == 3, "R3 active for D ticks after event", c0, 3);
        @(negedge clk);
        check(pwm_out[0] == 1'b0, "R3 inactive after expiry", int'(pwm_out[0]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule